// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the 32-bit data-processing unit of a load-store RISC core. Each cycle it takes an operation code, a first source value, and a second operand. The second operand is either a register value or a small unsigned immediate. The unit gives back a combinational result and a destination write strobe. It also keeps a four-bit condition-flag register that is updated on the clock edge.

The operations are:

- moves: plain and inverted;
- additions: plain and carry-in;
- subtractions: forward and reverse, each with or without a borrow taken from the carry flag;
- bitwise: AND, bit-clear, OR and XOR;
- two compares, which only set flags.

The operand shifter, the register file and the instruction decode are outside this block. The decoder places the operation code and the flag-set bit on the ports. The register file consumes the result and the write strobe.

Top module: `alu_core`

## Requirements
- R1: When `useImm` is 1, the second operand is `immVal` zero-extended to 32 bits and `op2Reg` is ignored. When `useImm` is 0, the second operand is `op2Reg`.
- R2: Code 2 (add) gives Rn+Op2. Code 3 (add with carry) gives Rn+Op2+C. Both are modulo 2^32.
- R3: Code 4 (subtract) gives Rn-Op2. Code 5 (subtract with borrow) gives Rn+~Op2+C, so C=1 means no borrow.
- R4: Code 6 (reverse subtract) gives Op2-Rn. Code 7 (reverse subtract with borrow) gives Op2+~Rn+C.
- R5: The logical and move codes are:
  - 0: Op2
  - 1: ~Op2
  - 8: Rn&Op2
  - 9: Rn&~Op2
  - 10: Rn|Op2
  - 11: Rn^Op2
- R6: Code 12 (compare, Rn-Op2) and code 13 (compare negative, Rn+Op2) hold `writeEn` at 0. They update all four flags on the next rising edge whatever the value of `setFlags`.
- R7: `writeEn` is 1 for codes 0 to 11.
- R8: `flagsQ` bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. After an arithmetic code with flag update enabled:
  - N is result bit 31.
  - Z is set when the result is zero.
  - C is the adder carry-out, which is NOT borrow for subtractions.
  - V is signed overflow.
- R9: A logical or move code with `setFlags`=1 updates N and Z and leaves C and V unchanged.
- R10: With `setFlags`=0, codes 0 to 11 leave `flagsQ` unchanged.
- R11: A synchronous reset (`rst`=1 at a rising edge) clears `flagsQ` to 0.
- R12: Codes 14 and 15 drive `result` to 0, hold `writeEn` at 0 and leave `flagsQ` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the flags, active high |
| opSel | input | 4 | Operation code |
| rnVal | input | 32 | First source operand |
| op2Reg | input | 32 | Register form of the second operand |
| immVal | input | 8 | Unsigned immediate form of the second operand |
| useImm | input | 1 | Selects the immediate as second operand |
| setFlags | input | 1 | Enables the flag update for non-compare codes |
| result | output | 32 | Combinational result |
| writeEn | output | 1 | Destination write strobe |
| flagsQ | output | 4 | Registered flags {N,Z,C,V} |

## Verification
In a carry-consuming operation, the flag register is read and rewritten in the same cycle. The current C feeds the adder while the next C is being formed. The bench provokes this with back-to-back chains: a subtract leaves a known carry, and then add-with-carry, subtract-with-borrow and reverse-with-borrow vectors run on consecutive cycles with flag-set on. Each result is judged against the carry that the previous vector left. The new flags are judged one edge later. Compares issued with flag-set off exercise the same overlap between the forced update and the suppressed write.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0,  OP_MVN = 4'd1,  OP_ADD = 4'd2,  OP_ADC = 4'd3,
    OP_SUB = 4'd4,  OP_SBC = 4'd5,  OP_RSB = 4'd6,  OP_RSC = 4'd7,
    OP_AND = 4'd8,  OP_BIC = 4'd9,  OP_ORR = 4'd10, OP_EOR = 4'd11,
    OP_CMP = 4'd12, OP_CMN = 4'd13, OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_e;

  typedef enum logic [2:0] {
    LG_PASS = 3'd0,
    LG_NOT  = 3'd1,
    LG_AND  = 3'd2,
    LG_BIC  = 3'd3,
    LG_ORR  = 3'd4,
    LG_EOR  = 3'd5,
    LG_ZERO = 3'd6
  } logic_e;

  typedef struct packed {
    logic   arith;
    logic   swapAB;
    logic   invB;
    cin_e   cinSel;
    logic_e logicSel;
    logic   wrEn;
    logic   updNZ;
    logic   updCV;
  } ctrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       setFlags,
  output ctrl_t      ctrl
);

  opcode_e opCode;
  logic    isCompare;
  logic    isValid;

  assign opCode    = opcode_e'(opSel);
  assign isCompare = (opCode == OP_CMP) || (opCode == OP_CMN);
  assign isValid   = (opCode != OP_RS14) && (opCode != OP_RS15);

  always_comb begin
    ctrl          = '0;
    ctrl.cinSel   = CIN_ZERO;
    ctrl.logicSel = LG_ZERO;
    unique case (opCode)
      OP_MOV: ctrl.logicSel = LG_PASS;
      OP_MVN: ctrl.logicSel = LG_NOT;
      OP_AND: ctrl.logicSel = LG_AND;
      OP_BIC: ctrl.logicSel = LG_BIC;
      OP_ORR: ctrl.logicSel = LG_ORR;
      OP_EOR: ctrl.logicSel = LG_EOR;
      OP_ADD, OP_CMN: ctrl.arith = 1'b1;
      OP_ADC: begin
        ctrl.arith  = 1'b1;
        ctrl.cinSel = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        ctrl.arith  = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.arith  = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl.arith  = 1'b1;
        ctrl.swapAB = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_ONE;
      end
      OP_RSC: begin
        ctrl.arith  = 1'b1;
        ctrl.swapAB = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cinSel = CIN_FLAG;
      end
      default: ctrl.logicSel = LG_ZERO;
    endcase
    ctrl.wrEn  = isValid && !isCompare;
    ctrl.updNZ = isValid && (setFlags || isCompare);
    ctrl.updCV = isValid && (setFlags || isCompare) && ctrl.arith;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [DataW-1:0] rnVal,
  input  logic [DataW-1:0] op2Reg,
  input  logic [ImmW-1:0]  immVal,
  input  logic             useImm,
  output logic [DataW-1:0] result,
  output logic [3:0]       flagsQ
);

  localparam int Msb = DataW - 1;

  logic [DataW-1:0] op2Val;
  logic [DataW-1:0] opA;
  logic [DataW-1:0] opB;
  logic [DataW-1:0] opBx;
  logic [DataW-1:0] logicRes;
  logic [DataW:0]   sumW;
  logic             carryIn;
  logic             nextN;
  logic             nextZ;
  logic             nextC;
  logic             nextV;

  assign op2Val = useImm ? {{(DataW-ImmW){1'b0}}, immVal} : op2Reg;

  always_comb begin
    opA  = ctrl.swapAB ? op2Val : rnVal;
    opB  = ctrl.swapAB ? rnVal  : op2Val;
    opBx = ctrl.invB ? ~opB : opB;
    unique case (ctrl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsQ[1];
      default:  carryIn = 1'b0;
    endcase
    sumW = {1'b0, opA} + {1'b0, opBx} + {{DataW{1'b0}}, carryIn};
  end

  always_comb begin
    unique case (ctrl.logicSel)
      LG_PASS: logicRes = op2Val;
      LG_NOT:  logicRes = ~op2Val;
      LG_AND:  logicRes = rnVal & op2Val;
      LG_BIC:  logicRes = rnVal & ~op2Val;
      LG_ORR:  logicRes = rnVal | op2Val;
      LG_EOR:  logicRes = rnVal ^ op2Val;
      default: logicRes = '0;
    endcase
  end

  assign result = ctrl.arith ? sumW[Msb:0] : logicRes;
  assign nextN  = result[Msb];
  assign nextZ  = (result == '0);
  assign nextC  = sumW[DataW];
  assign nextV  = (opA[Msb] == opBx[Msb]) && (sumW[Msb] != opA[Msb]);

  always_ff @(posedge clk) begin
    if (rst) begin
      flagsQ <= '0;
    end else begin
      if (ctrl.updNZ) flagsQ[3:2] <= {nextN, nextZ};
      if (ctrl.updCV) flagsQ[1:0] <= {nextC, nextV};
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       opSel,
  input  logic [DataW-1:0] rnVal,
  input  logic [DataW-1:0] op2Reg,
  input  logic [ImmW-1:0]  immVal,
  input  logic             useImm,
  input  logic             setFlags,
  output logic [DataW-1:0] result,
  output logic             writeEn,
  output logic [3:0]       flagsQ
);

  ctrl_t ctrl;

  alu_ctrl u_ctrl (
    .opSel    (opSel),
    .setFlags (setFlags),
    .ctrl     (ctrl)
  );

  alu_datapath #(.DataW(DataW), .ImmW(ImmW)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .rnVal  (rnVal),
    .op2Reg (op2Reg),
    .immVal (immVal),
    .useImm (useImm),
    .result (result),
    .flagsQ (flagsQ)
  );

  assign writeEn = ctrl.wrEn;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DataW = 32,
  parameter int ImmW  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       opSel,
  input logic [ImmW-1:0]  immVal,
  input logic             useImm,
  input logic             setFlags,
  input logic [DataW-1:0] result,
  input logic             writeEn,
  input logic [3:0]       flagsQ
);

  logic isCmp;
  logic isLogic;
  logic isArith;
  logic isSpare;

  assign isCmp   = (opSel == 4'd12) || (opSel == 4'd13);
  assign isSpare = (opSel == 4'd14) || (opSel == 4'd15);
  assign isLogic = (opSel <= 4'd1) || ((opSel >= 4'd8) && (opSel <= 4'd11));
  assign isArith = ((opSel >= 4'd2) && (opSel <= 4'd7)) || isCmp;

  p_imm_zext_r1: assert property (@(posedge clk) disable iff (rst)
    (useImm && opSel == 4'd0) |-> (result == {{(DataW-ImmW){1'b0}}, immVal}));

  p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    isCmp |-> !writeEn);

  p_write_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (!isCmp && !isSpare) |-> writeEn);

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (isArith && (setFlags || isCmp)) |=> (flagsQ[2] == ($past(result) == '0)));

  p_logic_keeps_cv_r9: assert property (@(posedge clk) disable iff (rst)
    isLogic |=> (flagsQ[1:0] == $past(flagsQ[1:0])));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!setFlags && !isCmp) |=> $stable(flagsQ));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (flagsQ == 4'd0));

  p_spare_idle_r12: assert property (@(posedge clk) disable iff (rst)
    isSpare |-> (!writeEn && result == '0));

endmodule

bind alu_core alu_core_chk #(.DataW(DataW), .ImmW(ImmW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opSel    (opSel),
  .immVal   (immVal),
  .useImm   (useImm),
  .setFlags (setFlags),
  .result   (result),
  .writeEn  (writeEn),
  .flagsQ   (flagsQ)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opSel = 4'd0;
  logic [31:0] rnVal = '0;
  logic [31:0] op2Reg = '0;
  logic [7:0]  immVal = '0;
  logic        useImm = 1'b0;
  logic        setFlags = 1'b0;
  logic [31:0] result;
  logic        writeEn;
  logic [3:0]  flagsQ;

  int   nChecks = 0;
  int   nFails  = 0;
  logic [3:0] expFlags = 4'd0;

  always #5 clk = ~clk;

  alu_core u_dut (
    .clk(clk), .rst(rst), .opSel(opSel), .rnVal(rnVal), .op2Reg(op2Reg),
    .immVal(immVal), .useImm(useImm), .setFlags(setFlags),
    .result(result), .writeEn(writeEn), .flagsQ(flagsQ)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference built from the requirement text
  task automatic applyVec(input string req, input int op, input logic [31:0] rn,
                          input logic [31:0] o2r, input logic [7:0] imm,
                          input logic ui, input logic sf);
    logic [31:0] b, x, y, r;
    logic [32:0] s;
    logic arith, cin, we, spare, cmp;
    b = ui ? {24'd0, imm} : o2r;
    arith = 1'b0; x = rn; y = b; cin = 1'b0; r = '0; s = '0;
    case (op)
      0:  r = b;
      1:  r = ~b;
      8:  r = rn & b;
      9:  r = rn & ~b;
      10: r = rn | b;
      11: r = rn ^ b;
      2, 13: begin arith = 1'b1; end
      3: begin arith = 1'b1; cin = expFlags[1]; end
      4, 12: begin arith = 1'b1; y = ~b; cin = 1'b1; end
      5: begin arith = 1'b1; y = ~b; cin = expFlags[1]; end
      6: begin arith = 1'b1; x = b; y = ~rn; cin = 1'b1; end
      7: begin arith = 1'b1; x = b; y = ~rn; cin = expFlags[1]; end
      default: r = '0;
    endcase
    if (arith) begin
      s = {1'b0, x} + {1'b0, y} + {32'd0, cin};
      r = s[31:0];
    end
    cmp   = (op == 12) || (op == 13);
    spare = (op >= 14);
    we    = !cmp && !spare;
    @(negedge clk);
    opSel = op[3:0]; rnVal = rn; op2Reg = o2r; immVal = imm;
    useImm = ui; setFlags = sf;
    #1;
    if (!cmp) check({req, " result"}, result, r);
    check({req, " writeEn"}, {31'd0, writeEn}, {31'd0, we});
    if (!spare && (sf || cmp)) begin
      expFlags[3] = r[31];
      expFlags[2] = (r == 32'd0);
      if (arith) begin
        expFlags[1] = s[32];
        expFlags[0] = (x[31] == y[31]) && (r[31] != x[31]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({req, " flags"}, {28'd0, flagsQ}, {28'd0, expFlags});
  endtask

  task automatic t_reset();
    check("R11 reset", {28'd0, flagsQ}, 32'd0);
  endtask

  task automatic t_immediate();
    applyVec("R1 imm mov", 0, 32'h1234_5678, 32'hDEAD_BEEF, 8'hFF, 1'b1, 1'b0);
    applyVec("R1 reg mov", 0, 32'h0, 32'hDEAD_BEEF, 8'hFF, 1'b0, 1'b0);
    applyVec("R1 imm add", 2, 32'h0000_0100, 32'hFFFF_FFFF, 8'h87, 1'b1, 1'b1);
  endtask

  task automatic t_add();
    applyVec("R8 add wrap", 2, 32'hFFFF_FFFF, 32'h1, 8'h0, 1'b0, 1'b1);
    applyVec("R2 adc c1", 3, 32'h10, 32'h20, 8'h0, 1'b0, 1'b1);
    applyVec("R8 add ovf", 2, 32'h7FFF_FFFF, 32'h1, 8'h0, 1'b0, 1'b1);
    applyVec("R2 adc c0", 3, 32'h10, 32'h20, 8'h0, 1'b0, 1'b1);
  endtask

  task automatic t_sub();
    applyVec("R3 sub eq", 4, 32'h55, 32'h0, 8'h55, 1'b1, 1'b1);
    applyVec("R3 sbc noborrow", 5, 32'h100, 32'h1, 8'h0, 1'b0, 1'b1);
    applyVec("R3 sub borrow", 4, 32'h1, 32'h2, 8'h0, 1'b0, 1'b1);
    applyVec("R3 sbc borrow", 5, 32'h100, 32'h1, 8'h0, 1'b0, 1'b1);
    applyVec("R8 sub ovf", 4, 32'h8000_0000, 32'h1, 8'h0, 1'b0, 1'b1);
  endtask

  task automatic t_reverse();
    applyVec("R4 rsb", 6, 32'h5, 32'h0, 8'h20, 1'b1, 1'b1);
    applyVec("R4 rsc c1", 7, 32'h5, 32'h20, 8'h0, 1'b0, 1'b1);
    applyVec("R4 rsb neg", 6, 32'h20, 32'h5, 8'h0, 1'b0, 1'b1);
    applyVec("R4 rsc c0", 7, 32'h5, 32'h20, 8'h0, 1'b0, 1'b1);
  endtask

  task automatic t_logic();
    applyVec("R8 set c", 2, 32'hFFFF_FFFF, 32'h2, 8'h0, 1'b0, 1'b1);
    applyVec("R5 mvn", 1, 32'h0, 32'h0F0F_0000, 8'h0, 1'b0, 1'b1);
    applyVec("R5 and", 8, 32'hF0F0_F0F0, 32'hFF00_FF00, 8'h0, 1'b0, 1'b1);
    applyVec("R5 bic", 9, 32'hF0F0_F0F0, 32'hFF00_FF00, 8'h0, 1'b0, 1'b1);
    applyVec("R5 orr", 10, 32'h0000_00F0, 32'h0, 8'h0F, 1'b1, 1'b1);
    applyVec("R9 eor zero", 11, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'h0, 1'b0, 1'b1);
  endtask

  task automatic t_compare();
    applyVec("R6 cmp eq", 12, 32'h87, 32'h0, 8'h87, 1'b1, 1'b0);
    applyVec("R6 cmp lt", 12, 32'h1, 32'h5, 8'h0, 1'b0, 1'b0);
    applyVec("R6 cmn", 13, 32'hFFFF_FFFF, 32'h1, 8'h0, 1'b0, 1'b0);
  endtask

  task automatic t_noflags();
    applyVec("R10 add nosf", 2, 32'h7FFF_FFFF, 32'h1, 8'h0, 1'b0, 1'b0);
    applyVec("R10 sub nosf", 4, 32'h0, 32'h1, 8'h0, 1'b0, 1'b0);
    applyVec("R10 mov nosf", 0, 32'h0, 32'h0, 8'h0, 1'b1, 1'b0);
  endtask

  task automatic t_spare();
    applyVec("R12 code14", 14, 32'hFFFF_FFFF, 32'h1, 8'h0, 1'b0, 1'b1);
    applyVec("R12 code15", 15, 32'h1, 32'h1, 8'h0, 1'b0, 1'b1);
  endtask

  task automatic t_reset_mid();
    applyVec("R7 mov sets n", 1, 32'h0, 32'h0, 8'h0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expFlags = 4'd0;
    check("R11 reset mid", {28'd0, flagsQ}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_immediate();
    t_add();
    t_sub();
    t_reverse();
    t_logic();
    t_compare();
    t_noflags();
    t_spare();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule